// File: doc/BRIEF.md
# Dual-Polynomial CRC32 Accumulator

This block advances a 32-bit CRC accumulator by one data item of 1, 2, 4 or 8 bytes. The caller presents the present accumulator value, a data word, a size code and a polynomial choice together with a one-cycle start strobe. The block consumes one byte per clock, lowest-order byte first, and raises a one-cycle done strobe once the last byte is folded in. At that point the new accumulator is on the result port.

Two bit-reflected generator polynomials are available and may be chosen per operation: the common CRC-32 polynomial and the Castagnoli polynomial. The block applies no pre-inversion or post-inversion. Any initial value or final complement belongs to the caller, which makes long messages easy to chain through successive operations.

Top module: `crc_dual_acc`

## Requirements
- R1: `poly_sel_i` = 0 selects the reflected polynomial 0xEDB88320; `poly_sel_i` = 1 selects the reflected polynomial 0x82F63B78. The choice is latched when an operation is accepted.
- R2: For each byte, the byte is XORed into accumulator bits 7:0. Eight steps follow, and each step shifts the accumulator right by one and XORs in the polynomial when the bit shifted out was 1.
- R3: `size_i` codes the item length: 0 = 1 byte (`data_i[7:0]`), 1 = 2 bytes (`data_i[15:0]`), 2 = 4 bytes (`data_i[31:0]`), 3 = 8 bytes. Data bits above the selected length have no effect on the result.
- R4: Multi-byte items are consumed byte by byte starting with `data_i[7:0]` and moving to higher bytes. A 9-byte message therefore gives the same result whether it is split as 8+1 or as 4+4+1 bytes.
- R5: The block neither complements the incoming accumulator nor the result. An all-zero accumulator with all-zero data gives zero.
- R6: `done_o` is high for exactly one cycle, N clock edges after the edge that accepts the start, where N is the byte count of R3.
- R7: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, and is low while `done_o` is high.
- R8: A start strobe while `busy_o` is high is ignored. The running operation keeps its timing and its result.
- R9: After a synchronous active-low reset, `busy_o` = 0, `done_o` = 0 and `crc_o` = 0.
- R10: While idle, `crc_o` keeps the last result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| size_i | input | 2 | Item length code (R3) |
| poly_sel_i | input | 1 | Polynomial choice (R1) |
| crc_i | input | 32 | Accumulator value to update |
| data_i | input | 64 | Data item, low byte first |
| crc_o | output | 32 | Updated accumulator |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Operation in progress |

## Verification
Stimulus comes from a vector table that sweeps every size code against both polynomials, using seeds of all ones, zero and arbitrary values. The table data carries garbage in the unused upper bytes, so a slip in byte order, polynomial choice or masking produces a different result. A well-known nine-byte ASCII message is run under both polynomials and under two different splits, which separates the polynomials from each other and checks the low-byte-first order. Directed cases cover an all-zero input (no hidden inversion), a start strobe sent mid-operation, and the result holding while idle.

// File: rtl/crc_acc_pkg.sv
// Package: shared constants and helpers for the dual-polynomial CRC accumulator.
// Assumes reflected (LSB-first) CRC arithmetic throughout.
package crc_acc_pkg;

    localparam int CRC_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 64;
    localparam int MAX_BYTES = DATA_W / BYTE_W;
    localparam int CNT_W   = $clog2(MAX_BYTES + 1);

    localparam logic [CRC_W-1:0] POLY_STD = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_CAS = 32'h82F63B78;

    typedef enum logic [1:0] {
        LEN_1B = 2'd0,
        LEN_2B = 2'd1,
        LEN_4B = 2'd2,
        LEN_8B = 2'd3
    } len_code_t;

    // Byte count for a length code.
    function automatic logic [CNT_W-1:0] len_bytes(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/crc_byte_step.sv
// crc_byte_step: folds one byte into a reflected CRC accumulator.
// Purely combinational; eight shift/conditional-XOR stages are unrolled.
// Assumes the polynomial is given in reflected form.
module crc_byte_step #(
    parameter int CRC_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic [CRC_W-1:0]  acc_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CRC_W-1:0]  poly_i,
    output logic [CRC_W-1:0]  acc_o
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    // Byte enters the low end of the accumulator.
    assign stage[0] = acc_i ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i};

    for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
        // One right shift with polynomial feedback on a shifted-out one.
        assign stage[k+1] = (stage[k] >> 1) ^ (stage[k][0] ? poly_i : '0);
    end

    assign acc_o = stage[BYTE_W];
endmodule

// File: rtl/crc_seq.sv
// crc_seq: sequences an operation of 1..MAX_BYTES bytes, one byte per cycle.
// Accepts a start only while idle; raises done for one cycle after the last byte.
// Synchronous active-low reset.
module crc_seq
    import crc_acc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] size_i,
    output logic       accept_o,
    output logic       advance_o,
    output logic       busy_o,
    output logic       done_o
);
    logic [CW-1:0] remain_q;

    assign accept_o  = start_i && !busy_o;
    assign advance_o = busy_o;

    // Remaining-byte counter, busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
        end else if (accept_o) begin
            remain_q <= CW'(len_bytes(size_i) - 1'b1);
            busy_o   <= 1'b1;
            done_o   <= 1'b0;
        end else if (busy_o) begin
            if (remain_q == '0) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else begin
                remain_q <= remain_q - 1'b1;
                done_o   <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
        end
    end
endmodule

// File: rtl/crc_dual_acc.sv
// crc_dual_acc: CRC32 accumulator update with a run-time choice of two reflected
// polynomials. Consumes the data item low byte first, one byte per clock.
// No inversion is applied on either side. Synchronous active-low reset.
module crc_dual_acc
    import crc_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic              poly_sel_i,
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              done_o,
    output logic              busy_o
);
    logic [CRC_W-1:0]  acc_q, acc_next, poly_q;
    logic [DATA_W-1:0] shreg_q;
    logic              accept, advance;

    crc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .size_i   (size_i),
        .accept_o (accept),
        .advance_o(advance),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    crc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_step (
        .acc_i (acc_q),
        .byte_i(shreg_q[BYTE_W-1:0]),
        .poly_i(poly_q),
        .acc_o (acc_next)
    );

    // Operand capture on accept; byte fold and data shift while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            shreg_q <= '0;
            poly_q  <= POLY_STD;
        end else if (accept) begin
            acc_q   <= crc_i;
            shreg_q <= data_i;
            poly_q  <= poly_sel_i ? POLY_CAS : POLY_STD;
        end else if (advance) begin
            acc_q   <= acc_next;
            shreg_q <= shreg_q >> BYTE_W;
        end
    end

    assign crc_o = acc_q;
endmodule

// File: rtl/crc_dual_acc_chk.sv
// crc_dual_acc_chk: temporal checks on the accumulator's ports, bound to crc_dual_acc.
module crc_dual_acc_chk
    import crc_acc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       size_i,
    input logic [CRC_W-1:0] crc_o,
    input logic             done_o,
    input logic             busy_o
);
    logic [CNT_W:0] elapsed_q, need_q;

    // Cycles since the accepted start, and the byte count it asked for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            need_q    <= '0;
        end else if (start_i && !busy_o) begin
            elapsed_q <= '0;
            need_q    <= (CNT_W+1)'(len_bytes(size_i));
        end else if (busy_o) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (elapsed_q == need_q));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(crc_o));
endmodule

bind crc_dual_acc crc_dual_acc_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .size_i (size_i),
    .crc_o  (crc_o),
    .done_o (done_o),
    .busy_o (busy_o)
);

// File: tb/sim_crc_dual_acc.sv
module sim_crc_dual_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        poly_sel_i = 1'b0;
    logic [31:0] crc_i = '0;
    logic [63:0] data_i = '0;
    logic [31:0] crc_o;
    logic        done_o, busy_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    crc_dual_acc u0 (.*);

    // Reference model written from R1..R4.
    function automatic logic [31:0] ref_crc(input logic [1:0] sz, input logic ps,
                                            input logic [31:0] c, input logic [63:0] d);
        logic [31:0] p = ps ? 32'h82F63B78 : 32'hEDB88320;
        for (int b = 0; b < (1 << sz); b++) begin
            c ^= {24'h0, d[8*b +: 8]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; returns the result and cycles from accept edge to done.
    task automatic run_op(input logic [1:0] sz, input logic ps, input logic [31:0] c,
                          input logic [63:0] d, input logic poke_busy,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        start_i = 1'b1; size_i = sz; poly_sel_i = ps; crc_i = c; data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        check("R7 busy after accept", busy_o, 1);
        lat = 0;
        if (poke_busy) begin
            start_i = 1'b1; size_i = 2'd0; poly_sel_i = ~ps; crc_i = ~c; data_i = ~d;
        end
        while (!done_o && lat < 20) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (!done_o) check("R7 busy during op", busy_o, 1);
        end
        check("R7 busy low with done", busy_o, 0);
        res = crc_o;
        @(negedge clk);
        check("R6 done single cycle", done_o, 0);
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic        ps;
        logic [31:0] c;
        logic [63:0] d;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'hFFFFFFFF, 64'hDEADBEEF_CAFE0031},
        '{2'd0, 1'b1, 32'hFFFFFFFF, 64'hDEADBEEF_CAFE0031},
        '{2'd1, 1'b0, 32'h12345678, 64'hAAAA5555_0F0FA5C3},
        '{2'd1, 1'b1, 32'h12345678, 64'hAAAA5555_0F0FA5C3},
        '{2'd2, 1'b0, 32'h00000000, 64'hFFFFFFFF_01020304},
        '{2'd2, 1'b1, 32'hA5A5A5A5, 64'h13579BDF_89ABCDEF},
        '{2'd3, 1'b0, 32'hFFFFFFFF, 64'h01234567_89ABCDEF},
        '{2'd3, 1'b1, 32'hFFFFFFFF, 64'h01234567_89ABCDEF},
        '{2'd3, 1'b0, 32'h80000001, 64'h80000000_00000001},
        '{2'd2, 1'b0, 32'h00000001, 64'h00000000_00000080}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r, r2;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 busy", busy_o, 0);
        check("R9 done", done_o, 0);
        check("R9 crc", crc_o, 0);

        // R1 R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].sz, VECS[i].ps, VECS[i].c, VECS[i].d, 1'b0, r, lat);
            check("R1 R2 R3 table result", r, ref_crc(VECS[i].sz, VECS[i].ps, VECS[i].c, VECS[i].d));
            check("R6 latency", lat, 1 << VECS[i].sz);
        end

        // R4 R1 known message "123456789" split 8+1, raw (uncomplemented) results
        run_op(2'd3, 1'b0, 32'hFFFFFFFF, 64'h38373635_34333231, 1'b0, r, lat);
        run_op(2'd0, 1'b0, r, 64'h39, 1'b0, r, lat);
        check("R4 R1 standard 8+1", r, 32'h340BC6D9);
        run_op(2'd3, 1'b1, 32'hFFFFFFFF, 64'h38373635_34333231, 1'b0, r, lat);
        run_op(2'd0, 1'b1, r, 64'h39, 1'b0, r, lat);
        check("R4 R1 castagnoli 8+1", r, 32'h1CF96D7C);
        // R4 split 4+4+1
        run_op(2'd2, 1'b0, 32'hFFFFFFFF, 64'hFFFF0000_34333231, 1'b0, r, lat);
        run_op(2'd2, 1'b0, r, 64'h12340000_38373635, 1'b0, r, lat);
        run_op(2'd0, 1'b0, r, 64'hFF39, 1'b0, r, lat);
        check("R4 standard 4+4+1", r, 32'h340BC6D9);

        // R5 zero in, zero out
        run_op(2'd3, 1'b0, 32'h0, 64'h0, 1'b0, r, lat);
        check("R5 no inversion", r, 32'h0);

        // R3 upper bits ignored
        run_op(2'd1, 1'b1, 32'h0BADF00D, 64'h00000000_00001234, 1'b0, r, lat);
        run_op(2'd1, 1'b1, 32'h0BADF00D, 64'hFFFFFFFF_FFFF1234, 1'b0, r2, lat);
        check("R3 upper bits ignored", r2, r);

        // R8 start while busy ignored
        run_op(2'd3, 1'b0, 32'hCAFEBABE, 64'h11223344_55667788, 1'b1, r, lat);
        check("R8 result kept", r, ref_crc(2'd3, 1'b0, 32'hCAFEBABE, 64'h11223344_55667788));
        check("R8 timing kept", lat, 8);

        // R10 result holds while idle
        repeat (5) @(negedge clk);
        check("R10 hold", crc_o, r);
        check("R10 idle", busy_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule